// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock for an I2C master. A free-running divide-by-four prescaler makes a timing tick, and every phase count in the block advances only on that tick. The generator pulls SCL low through an open-drain enable for a programmed number of ticks, then releases the line. It does not start counting the high phase until it sees the line high through a two-flop synchronizer. A slow bus rise, or a target holding SCL low, therefore lengthens the period by whole ticks.

A 32-bit configuration register sets the timing and the mode. It holds a 9-bit reference value, a fast-mode select and an interrupt-disable bit. In standard mode each phase lasts reference+2 ticks. Fast mode cuts the fixed part of the period to three quarters of that, with two thirds of it spent low. The byte-level engine uses two single-cycle strobes. One marks the falling edge, where data may change. The other marks the detected rising edge, where data is sampled. The engine's interrupt request is passed out through the mask bit.

Top module: `i2c_scl_gen`

## Requirements
- R1: The configuration register resets to zero. A write stores the reference value in bits 8:0, the fast-mode select in bit 12 and the interrupt-disable bit in bit 15. On read-back every other bit is zero, so writing all ones reads back 0x000091FF.
- R2: The `irq` output follows `irq_req` while the interrupt-disable bit (bit 15) is 0, and stays 0 while that bit is 1.
- R3: The timing tick fires once every 4 clock cycles, and SCL phase boundaries occur only on ticks. Every measured phase length is a multiple of 4 clock cycles.
- R4: In standard mode (bit 12 = 0) with reference value C, the low phase lasts C+2 ticks. The high phase lasts C+2 ticks counted from the tick that detects SCL high. The period is 2C+4 ticks plus the rise delay.
- R5: In fast mode (bit 12 = 1), let F = floor(3*(2C+4)/4). The low phase lasts floor(2F/3) ticks and the high phase lasts the rest of F, counted from the detection tick. If the high share is one tick, both strobes fire in the same cycle.
- R6: After SCL is released, high-phase counting starts only at the first tick at which the synchronized SCL input is 1. If the line rises d clock cycles after release, the detection tick is ceil((d+3)/4) ticks after release, with a minimum of one.
- R7: `fall_stb` is a one-cycle pulse in the cycle `scl_oe` goes to 1. `rise_stb` is a one-cycle pulse on the detection tick.
- R8: While `enable` is 0, `scl_oe` is 0 and neither strobe fires. Dropping `enable` during a low phase releases SCL one cycle later. Raising `enable` starts a low phase on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the SCL generator |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back |
| scl_in | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | Open-drain enable, 1 pulls SCL low |
| fall_stb | output | 1 | Pulse at SCL falling edge (data change point) |
| rise_stb | output | 1 | Pulse when SCL is detected high (data sample point) |
| irq_req | input | 1 | Interrupt request from the byte engine |
| irq | output | 1 | Masked interrupt output |

## Verification
The assertions assume that `enable` and the configuration only change while the generator is idle or at quiet points. They also assume that `scl_in` is low whenever `scl_oe` is 1, as open-drain wiring ensures. The bench models the bus as a wired line. It forces the line low immediately when `scl_oe` is 1, and raises it a chosen number of cycles after release. It writes the register only while `enable` is 0 and changes `enable` on falling clock edges. Rise delays are chosen to cover both the no-extra-tick case and multi-tick stretching.

// File: rtl/i2c_scl_pkg.sv
// Package: shared types and field positions for the SCL generator.
// Assumes the configuration register is 32 bits wide with fixed field positions.
package i2c_scl_pkg;

    localparam int REF_W       = 9;
    localparam int FAST_BIT    = 12;
    localparam int IRQ_DIS_BIT = 15;

    typedef struct packed {
        logic             irq_dis;
        logic             fast;
        logic [REF_W-1:0] clref;
    } scl_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_t;

endpackage

// File: rtl/scl_tick_div.sv
// Free-running prescaler: emits a one-cycle tick every DIV clock cycles.
// Assumes DIV >= 2; the count starts at zero after reset.
module scl_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    // Count 0..DIV-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == CW'(DIV - 1));

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/scl_cfg_reg.sv
// Configuration register: reference value, fast-mode select, interrupt disable.
// Unimplemented bits are dropped on write and read back as zero.
module scl_cfg_reg
    import i2c_scl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output scl_cfg_t    cfg
);
    scl_cfg_t cfg_q;
    logic     unused_wbits;

    // Capture the implemented fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (we) begin
            cfg_q.clref   <= wdata[REF_W-1:0];
            cfg_q.fast    <= wdata[FAST_BIT];
            cfg_q.irq_dis <= wdata[IRQ_DIS_BIT];
        end
    end

    // Assemble the read-back word with reserved bits at zero.
    always_comb begin
        rdata              = '0;
        rdata[REF_W-1:0]   = cfg_q.clref;
        rdata[FAST_BIT]    = cfg_q.fast;
        rdata[IRQ_DIS_BIT] = cfg_q.irq_dis;
    end

    assign unused_wbits = ^{wdata[31:IRQ_DIS_BIT+1], wdata[IRQ_DIS_BIT-1:FAST_BIT+1],
                            wdata[FAST_BIT-1:REF_W]};
    assign cfg = cfg_q;

    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata[REF_W-1:0] == $past(wdata[REF_W-1:0])) &&
               (rdata[IRQ_DIS_BIT] == $past(wdata[IRQ_DIS_BIT])));

endmodule

// File: rtl/scl_phase_fsm.sv
// SCL phase sequencer: counts low and high phases in timing ticks.
// It starts the high count only once the synchronized line reads high.
// Assumes the configuration only changes while enable is 0.
module scl_phase_fsm
    import i2c_scl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     enable,
    input  scl_cfg_t cfg,
    input  logic     scl_in,
    output logic     scl_oe,
    output logic     fall_stb,
    output logic     rise_stb
);
    localparam int CNT_W = REF_W + 3;
    localparam int MUL_W = CNT_W + 2;

    scl_phase_t             ph_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   scl_s;
    logic [CNT_W-1:0]       base_len, std_len, fast_tot, fast_low, fast_high;
    logic [CNT_W-1:0]       low_len, high_len;
    logic [MUL_W-1:0]       triple;

    // Bring the SCL line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[SYNC_STAGES-2:0], scl_in};
    end
    assign scl_s = sync_q[SYNC_STAGES-1];

    // Derive phase lengths for both modes from the reference value.
    always_comb begin
        base_len  = {2'b00, cfg.clref, 1'b0} + CNT_W'(4);
        std_len   = CNT_W'(cfg.clref) + CNT_W'(2);
        triple    = MUL_W'(base_len) * MUL_W'(3);
        fast_tot  = CNT_W'(triple >> 2);
        fast_low  = CNT_W'((MUL_W'(fast_tot) << 1) / MUL_W'(3));
        fast_high = fast_tot - fast_low;
        low_len   = cfg.fast ? fast_low  : std_len;
        high_len  = cfg.fast ? fast_high : std_len;
    end

    // Phase state, tick counter and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= PH_IDLE;
            cnt_q    <= '0;
            fall_stb <= 1'b0;
            rise_stb <= 1'b0;
        end else if (!enable) begin
            ph_q     <= PH_IDLE;
            cnt_q    <= '0;
            fall_stb <= 1'b0;
            rise_stb <= 1'b0;
        end else begin
            fall_stb <= 1'b0;
            rise_stb <= 1'b0;
            if (tick) begin
                unique case (ph_q)
                    PH_IDLE: begin
                        ph_q     <= PH_LOW;
                        cnt_q    <= '0;
                        fall_stb <= 1'b1;
                    end
                    PH_LOW: begin
                        if (cnt_q == low_len - 1'b1) begin
                            ph_q  <= PH_WAIT;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_WAIT: begin
                        if (scl_s) begin
                            rise_stb <= 1'b1;
                            if (high_len == CNT_W'(1)) begin
                                ph_q     <= PH_LOW;
                                cnt_q    <= '0;
                                fall_stb <= 1'b1;
                            end else begin
                                ph_q  <= PH_HIGH;
                                cnt_q <= CNT_W'(1);
                            end
                        end
                    end
                    PH_HIGH: begin
                        if (cnt_q == high_len - 1'b1) begin
                            ph_q     <= PH_LOW;
                            cnt_q    <= '0;
                            fall_stb <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: ph_q <= PH_IDLE;
                endcase
            end
        end
    end

    assign scl_oe = (ph_q == PH_LOW);

    assert_fall_pulls_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> scl_oe);
    assert_fall_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !fall_stb);
    assert_rise_seen_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> $past(scl_s));
    assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !scl_oe && !fall_stb && !rise_stb);
    assert_low_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_LOW) |-> (cnt_q < low_len));

endmodule

// File: rtl/i2c_scl_gen.sv
// Top level: prescaler, configuration register and SCL phase sequencer.
// Also masks the byte engine's interrupt request.
// Assumes scl_in reflects the wired bus line, low whenever scl_oe is 1.
module i2c_scl_gen
    import i2c_scl_pkg::*;
#(
    parameter int TICK_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        scl_in,
    output logic        scl_oe,
    output logic        fall_stb,
    output logic        rise_stb,
    input  logic        irq_req,
    output logic        irq
);
    logic     tick;
    scl_cfg_t cfg;

    scl_tick_div #(.DIV(TICK_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    scl_cfg_reg u_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cfg_we),
        .wdata(cfg_wdata),
        .rdata(cfg_rdata),
        .cfg  (cfg)
    );

    scl_phase_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .enable  (enable),
        .cfg     (cfg),
        .scl_in  (scl_in),
        .scl_oe  (scl_oe),
        .fall_stb(fall_stb),
        .rise_stb(rise_stb)
    );

    // Gate the interrupt request with the disable bit.
    assign irq = irq_req & ~cfg.irq_dis;

    assert_irq_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[IRQ_DIS_BIT] && irq_req) |-> !irq);

endmodule

// File: tb/i2c_scl_gen_tb_top.sv
// Bench: table-driven period measurement followed by directed register, interrupt and idle tests.
module i2c_scl_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam int V_CLREF[NV] = '{0, 0, 4, 4, 10, 10, 3, 7};
    localparam int V_FAST [NV] = '{0, 1, 0, 1, 0,  1,  0, 1};
    localparam int V_DLY  [NV] = '{0, 0, 0, 0, 5,  9,  1, 2};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        scl_in;
    logic        scl_oe, fall_stb, rise_stb;
    logic        irq_req = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int rise_dly = 0;
    int rel_cnt = 0;
    logic line = 1'b1;

    i2c_scl_gen dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .scl_in(scl_in),
        .scl_oe(scl_oe), .fall_stb(fall_stb), .rise_stb(rise_stb),
        .irq_req(irq_req), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Wired bus: pulled low at once, rises rise_dly cycles after release.
    always @(negedge clk) begin
        if (scl_oe) begin
            rel_cnt <= 0;
            line    <= 1'b0;
        end else begin
            rel_cnt <= rel_cnt + 1;
            line    <= ((rel_cnt + 1) >= rise_dly + 1);
        end
    end
    assign scl_in = line & ~scl_oe;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_fall(output int t);
        do @(negedge clk); while (!fall_stb);
        t = cyc;
    endtask

    // Measure one full SCL cycle: fall, rise, next fall.
    task automatic measure(output int lo, output int hi);
        int t0, tr, t1;
        wait_fall(t0);
        wait_fall(t0);
        do @(negedge clk); while (!rise_stb);
        tr = cyc;
        if (fall_stb) t1 = tr;
        else wait_fall(t1);
        lo = tr - t0;
        hi = t1 - tr;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int lo, hi, c, f, tot, el, eh, j;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset readback", cfg_rdata, 0);
        check("R8 reset oe", scl_oe, 0);

        // Table of modes, reference values and rise delays.
        for (int i = 0; i < NV; i++) begin
            enable = 1'b0;
            write_cfg((V_FAST[i] != 0 ? 32'h1000 : 32'h0) | 32'(V_CLREF[i]));
            rise_dly = V_DLY[i];
            enable = 1'b1;
            measure(lo, hi);
            c = V_CLREF[i];
            if (V_FAST[i] != 0) begin
                tot = (3 * (2 * c + 4)) / 4;
                el = (2 * tot) / 3;
                eh = tot - el;
            end else begin
                el = c + 2;
                eh = c + 2;
            end
            j = (V_DLY[i] + 6) / 4;
            // R4 R5 R6 R3: lengths are whole ticks of 4 cycles
            check(V_FAST[i] != 0 ? "R5 low+detect" : "R4 low+detect", lo, 4 * (el + j));
            check(V_FAST[i] != 0 ? "R5 high" : "R4 high", hi, 4 * (eh - 1));
            check("R6 R3 period", lo + hi, 4 * (el + eh + j - 1));
        end

        // R4: largest reference value, no rise delay.
        enable = 1'b0;
        write_cfg(32'h1FF);
        rise_dly = 0;
        enable = 1'b1;
        measure(lo, hi);
        check("R4 max clref period", lo + hi, 4 * 1026);

        // R8: dropping enable mid low phase releases SCL one cycle later.
        wait_fall(lo);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R8 release after disable", scl_oe, 0);
        f = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (scl_oe || fall_stb || rise_stb) f++;
        end
        check("R8 idle activity", f, 0);

        // R8: restart lands on a tick with a falling strobe.
        enable = 1'b1;
        f = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (fall_stb && scl_oe) f++;
        end
        check("R8 R7 restart within one tick", f, 1);
        enable = 1'b0;

        // R1: field positions and reserved bits.
        write_cfg(32'hFFFF_FFFF);
        check("R1 all-ones readback", cfg_rdata, 32'h0000_91FF);
        write_cfg(32'h0000_1055);
        check("R1 partial readback", cfg_rdata, 32'h0000_1055);

        // R2: interrupt masking.
        irq_req = 1'b1;
        @(negedge clk);
        check("R2 irq passes", irq, 1);
        write_cfg(32'h0000_8000);
        check("R2 irq masked", irq, 0);
        write_cfg(32'h0);
        check("R2 irq unmasked", irq, 1);
        irq_req = 1'b0;
        @(negedge clk);
        check("R2 irq follows req", irq, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule